// File: doc/BRIEF.md
# Tripartite First-Quadrant Sine Evaluator

This block turns an unsigned phase fraction into the amplitude of a quarter sine wave. The phase `p` of `PHASE_W` bits stands for the angle `(p + 0.5) / 2^PHASE_W * pi/2`. The block returns `round(sin(angle) * (2^AMP_W - 1))`, to within a small approximation error. It is meant to sit behind quadrant folding logic in a synthesizer datapath. It takes one phase per clock and gives one amplitude per clock after a fixed delay.

The block does not store a full table. It splits the phase into four fields that do not overlap: `a`, `b`, `c` and `d`, from most to least significant.
- A table of segment midpoint values is read with `{a, b}`.
- Two small correction tables are read with `{a, c}` and `{a, d}`. Both share the field `a`.
- Each correction table keeps only magnitudes for one half of the segment. The top bit of its own field picks whether the term is added or subtracted.

The three terms carry guard bits below the output LSB. A three-operand adder sums them, then the sum is rounded and clamped.

There are three register stages: on the table addresses, on the table outputs, and in the middle of the adder. All table contents are computed at elaboration by constant functions.

Top module: `mpsin_eval`

## Requirements
- R1: The phase is split MSB first into `a` (5 bits, [11:7]), `b` (2 bits, [6:5]), `c` (3 bits, [4:2]) and `d` (2 bits, [1:0]), whose widths add up to the 12-bit phase. The midpoint table is addressed by `{a,b}`, the first correction table by `{a, c[1:0] folded}` and the second by `{a, d[0] folded}`.
- R2: For each correction table, when the top bit of its field is 1 the remaining bits address the table directly and the term is added. When that bit is 0, the remaining bits are ones'-complemented before addressing and the term is subtracted.
- R3: The three terms carry 2 guard bits. The output is formed by adding half an output LSB (value 2 in guard units) to the sum, then dropping the guard bits. Over all phases this gives no systematic bias: the mean error is within ±0.2 LSB.
- R4: For every phase, the output differs from `sin(pi/2*(p+0.5)/4096)*4095` by at most 2 LSB.
- R5: A phase sampled with `inValid` high at a rising edge gives its amplitude, with `validOut` high, right after the third rising edge counting that one. `validOut` reproduces the `inValid` sequence three edges later.
- R6: While `validOut` is low, `ampOut` keeps its previous value, whatever phase is applied.
- R7: While `rstN` is low, `validOut` and `ampOut` are 0.
- R8: The result is clamped to [0, 4095]. Phase 0 gives at most 2 and phase 4095 gives at least 4093.
- R9: The midpoint table holds the sine at the centre of each `{a,b}` segment. Each correction table entry is the chord slope of its `a` interval times the signed distance of the folded field value (r + 0.5 units) from that centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Phase on `phaseIn` is to be evaluated |
| phaseIn | input | 12 | Unsigned phase fraction of the quarter period |
| validOut | output | 1 | `ampOut` carries a new result |
| ampOut | output | 12 | Unsigned sine amplitude |

## Verification
The bench sweeps every phase and checks each result against a real-valued sine. If an add/subtract choice were swapped or a complement were missing, the error inside the affected segment halves would be several LSB. A mean-error check over the full sweep catches a missing half-LSB rounding term, which otherwise stays inside the tolerance but pulls every result down by about 0.4 LSB. Directed phases cover 0 and full scale, where a missing clamp would wrap or go negative, and pairs of phases on either side of a field boundary, where wrong field slicing shows up as a jump. Random gaps in `inValid`, with junk phases applied, show whether the output moves without a valid result or the valid flag drifts out of step with the data.

// File: rtl/mpsin_pkg.sv
package mpsin_pkg;

  localparam int PHASE_W = 12;
  localparam int A_W     = 5;
  localparam int B_W     = 2;
  localparam int C_W     = 3;
  localparam int D_W     = 2;
  localparam int AMP_W   = 12;
  localparam int GUARD_W = 2;

  localparam int TIV_AW = A_W + B_W;
  localparam int TO1_AW = A_W + C_W - 1;
  localparam int TO2_AW = A_W + D_W - 1;
  localparam int TIV_DW = AMP_W + GUARD_W;
  localparam int TO1_DW = 8;
  localparam int TO2_DW = 5;
  localparam int SUM_W  = TIV_DW + 2;

  localparam int KIND_MID  = 0;
  localparam int KIND_OFS1 = 1;
  localparam int KIND_OFS2 = 2;

  // per-stage load strobes handed from control to datapath
  typedef struct packed {
    logic s1;
    logic s2;
    logic s3;
  } stageEn_t;

  localparam real HALF_PI = 1.5707963267948966;

  // sin(x * pi/2) for x in [0,1] by a Taylor series
  function automatic real quarterSine(real x);
    real ang, term, acc;
    ang  = x * HALF_PI;
    term = ang;
    acc  = ang;
    for (int k = 1; k <= 8; k++) begin
      term = -term * ang * ang / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real unitWeight(int bits);
    return 1.0 / real'(longint'(1) << bits);
  endfunction

  // chord slope of the curve across one a-interval
  function automatic real groupSlope(int aIdx);
    real w;
    w = unitWeight(A_W);
    return (quarterSine(real'(aIdx + 1) * w) - quarterSine(real'(aIdx) * w)) / w;
  endfunction

  function automatic int tableEntry(int kind, int idx);
    real fullScale, wC, wD, x, v;
    int  aIdx, rIdx;
    fullScale = real'((1 << AMP_W) - 1) * real'(1 << GUARD_W);
    wC = unitWeight(A_W + B_W + C_W);
    wD = unitWeight(PHASE_W);
    if (kind == KIND_MID) begin
      x = real'(idx) * unitWeight(TIV_AW)
        + (real'(1 << (C_W - 1)) - 0.5) * wC
        + real'(1 << (D_W - 1)) * wD;
      v = quarterSine(x) * fullScale;
    end else if (kind == KIND_OFS1) begin
      aIdx = idx >> (C_W - 1);
      rIdx = idx & ((1 << (C_W - 1)) - 1);
      v = groupSlope(aIdx) * (real'(rIdx) + 0.5) * wC * fullScale;
    end else begin
      aIdx = idx >> (D_W - 1);
      rIdx = idx & ((1 << (D_W - 1)) - 1);
      v = groupSlope(aIdx) * (real'(rIdx) + 0.5) * wD * fullScale;
    end
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/mpsin_rom.sv
module mpsin_rom #(
  parameter int KIND = 0,
  parameter int AW   = 7,
  parameter int DW   = 14
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] contents [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int VAL = mpsin_pkg::tableEntry(KIND, i);
    assign contents[i] = DW'(VAL);
  end

  assign data = contents[addr];
endmodule

// File: rtl/mpsin_ctrl.sv
module mpsin_ctrl
  import mpsin_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output stageEn_t stageEn,
  output logic     validOut
);
  logic v1, v2, v3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  assign stageEn  = '{s1: inValid, s2: v1, s3: v2};
  assign validOut = v3;
endmodule

// File: rtl/mpsin_dp.sv
module mpsin_dp
  import mpsin_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  stageEn_t           stageEn,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic [AMP_W-1:0]   ampOut
);
  localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1 << (GUARD_W - 1));
  localparam logic signed [SUM_W-1:0] MAX_AMP  = SUM_W'((1 << AMP_W) - 1);

  // field slicing
  logic [A_W-1:0] fieldA;
  logic [B_W-1:0] fieldB;
  logic [C_W-1:0] fieldC;
  logic [D_W-1:0] fieldD;
  assign fieldA = phaseIn[PHASE_W-1 -: A_W];
  assign fieldB = phaseIn[PHASE_W-A_W-1 -: B_W];
  assign fieldC = phaseIn[D_W +: C_W];
  assign fieldD = phaseIn[0 +: D_W];

  logic [C_W-2:0] restC;
  logic [D_W-2:0] restD;
  assign restC = fieldC[C_W-1] ? fieldC[C_W-2:0] : ~fieldC[C_W-2:0];
  assign restD = fieldD[D_W-1] ? fieldD[D_W-2:0] : ~fieldD[D_W-2:0];

  // stage 1: table addresses
  logic [TIV_AW-1:0] midAddrQ;
  logic [TO1_AW-1:0] ofs1AddrQ;
  logic [TO2_AW-1:0] ofs2AddrQ;
  logic              add1S1, add2S1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      midAddrQ  <= '0;
      ofs1AddrQ <= '0;
      ofs2AddrQ <= '0;
      add1S1    <= 1'b0;
      add2S1    <= 1'b0;
    end else if (stageEn.s1) begin
      midAddrQ  <= {fieldA, fieldB};
      ofs1AddrQ <= {fieldA, restC};
      ofs2AddrQ <= {fieldA, restD};
      add1S1    <= fieldC[C_W-1];
      add2S1    <= fieldD[D_W-1];
    end
  end

  logic [TIV_DW-1:0] midRd;
  logic [TO1_DW-1:0] ofs1Rd;
  logic [TO2_DW-1:0] ofs2Rd;

  mpsin_rom #(.KIND(KIND_MID),  .AW(TIV_AW), .DW(TIV_DW)) u_midRom  (.addr(midAddrQ),  .data(midRd));
  mpsin_rom #(.KIND(KIND_OFS1), .AW(TO1_AW), .DW(TO1_DW)) u_ofs1Rom (.addr(ofs1AddrQ), .data(ofs1Rd));
  mpsin_rom #(.KIND(KIND_OFS2), .AW(TO2_AW), .DW(TO2_DW)) u_ofs2Rom (.addr(ofs2AddrQ), .data(ofs2Rd));

  // stage 2: table outputs
  logic [TIV_DW-1:0] midQ;
  logic [TO1_DW-1:0] ofs1Q;
  logic [TO2_DW-1:0] ofs2Q;
  logic              add1S2, add2S2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      midQ   <= '0;
      ofs1Q  <= '0;
      ofs2Q  <= '0;
      add1S2 <= 1'b0;
      add2S2 <= 1'b0;
    end else if (stageEn.s2) begin
      midQ   <= midRd;
      ofs1Q  <= ofs1Rd;
      ofs2Q  <= ofs2Rd;
      add1S2 <= add1S1;
      add2S2 <= add2S1;
    end
  end

  // stage 3: split of the three-operand adder
  logic signed [SUM_W-1:0] midExt, ofs1Ext, ofs2Ext;
  assign midExt  = $signed({{(SUM_W-TIV_DW){1'b0}}, midQ});
  assign ofs1Ext = $signed({{(SUM_W-TO1_DW){1'b0}}, ofs1Q});
  assign ofs2Ext = $signed({{(SUM_W-TO2_DW){1'b0}}, ofs2Q});

  logic signed [SUM_W-1:0] partQ, ofs2TermQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partQ     <= '0;
      ofs2TermQ <= '0;
    end else if (stageEn.s3) begin
      partQ     <= add1S2 ? midExt + ofs1Ext : midExt - ofs1Ext;
      ofs2TermQ <= add2S2 ? ofs2Ext : -ofs2Ext;
    end
  end

  // final addition, rounding and clamping
  logic signed [SUM_W-1:0] totalSum, scaled;

  always_comb begin
    totalSum = partQ + ofs2TermQ + HALF_LSB;
    scaled   = totalSum >>> GUARD_W;
    if (scaled < 0)             ampOut = '0;
    else if (scaled > MAX_AMP)  ampOut = MAX_AMP[AMP_W-1:0];
    else                        ampOut = scaled[AMP_W-1:0];
  end
endmodule

// File: rtl/mpsin_eval.sv
module mpsin_eval
  import mpsin_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic               validOut,
  output logic [AMP_W-1:0]   ampOut
);
  stageEn_t stageEn;

  mpsin_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stageEn  (stageEn),
    .validOut (validOut)
  );

  mpsin_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stageEn (stageEn),
    .phaseIn (phaseIn),
    .ampOut  (ampOut)
  );
endmodule

// File: rtl/mpsin_eval_chk.sv
module mpsin_eval_chk
  import mpsin_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [PHASE_W-1:0] phaseIn,
  input logic               validOut,
  input logic [AMP_W-1:0]   ampOut
);
  localparam logic [AMP_W-1:0]   FULL_AMP   = '1;
  localparam logic [PHASE_W-1:0] FULL_PHASE = '1;

  logic [1:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign warm = (sinceRst == 2'd3);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (validOut == $past(inValid, 3))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable(ampOut)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (!validOut && ampOut == '0)); // R7

  AST_ZERO_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (warm && validOut && $past(phaseIn, 3) == '0) |-> (ampOut <= AMP_W'(2))); // R8

  AST_FULL_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (warm && validOut && $past(phaseIn, 3) == FULL_PHASE) |-> (ampOut >= FULL_AMP - AMP_W'(2))); // R8
endmodule

bind mpsin_eval mpsin_eval_chk u_chk (.*);

// File: tb/mpsin_eval_test.sv
`timescale 1ns/1ps
module mpsin_eval_test;
  localparam int  PW    = 12;
  localparam int  AW    = 12;
  localparam int  HMAX  = 8192;
  localparam real HP    = 1.5707963267948966;
  localparam real TOL   = 2.0;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [PW-1:0] phaseIn = '0;
  logic          validOut;
  logic [AW-1:0] ampOut;

  mpsin_eval uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .phaseIn(phaseIn),
    .validOut(validOut), .ampOut(ampOut)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int cyc     = 0;

  logic [PW-1:0] phHist [HMAX];
  bit            vHist  [HMAX];
  string         tagHist[HMAX];
  logic [AW-1:0] prevAmp;
  real           errSum = 0.0;
  int            errN   = 0;

  task automatic check(bit ok, string tag, string what, real act, real exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", tag, what, act, exp);
    end
  endtask

  function automatic real idealAmp(logic [PW-1:0] p);
    return $sin(HP * (real'(p) + 0.5) / 4096.0) * 4095.0;
  endfunction

  task automatic evaluate(int k);
    real ideal, err;
    if (k < 0) begin
      prevAmp = ampOut;
      return;
    end
    check(validOut == vHist[k], "R5", "validOut", real'(validOut), real'(vHist[k]));
    if (vHist[k]) begin
      ideal = idealAmp(phHist[k]);
      err   = real'(ampOut) - ideal;
      check(err <= TOL && err >= -TOL, tagHist[k], $sformatf("amp phase=%0d", phHist[k]),
            real'(ampOut), ideal);
      errSum += err;
      errN++;
    end else begin
      check(ampOut == prevAmp, "R6", "idle hold", real'(ampOut), real'(prevAmp));
    end
    prevAmp = ampOut;
  endtask

  task automatic step(bit v, logic [PW-1:0] p, string tag);
    @(negedge clk);
    evaluate(cyc - 3);
    inValid     = v;
    phaseIn     = p;
    vHist[cyc]  = v;
    phHist[cyc] = p;
    tagHist[cyc] = tag;
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(validOut == 1'b0, "R7", "reset validOut", real'(validOut), 0.0);
    check(ampOut == '0, "R7", "reset ampOut", real'(ampOut), 0.0);
    rstN = 1'b1;

    // full sweep of every phase, back to back
    for (int p = 0; p < 4096; p++) step(1'b1, PW'(p), "R4");

    // directed corners
    step(1'b1, 12'd0,    "R8");
    step(1'b1, 12'd4095, "R8");
    step(1'b1, 12'd4094, "R8");
    step(1'b1, 12'd1327, "R2");   // c=011 d=11: subtract side of first offset
    step(1'b1, 12'd1328, "R2");   // c=100 d=00: add side of first offset
    step(1'b1, 12'd1329, "R1");   // d step inside one c value
    step(1'b1, 12'd1330, "R1");   // d top bit flips
    step(1'b0, 12'd4095, "R6");
    step(1'b0, 12'd0,    "R6");
    step(1'b1, 12'd2063, "R9");   // just below a segment centre
    step(1'b1, 12'd2064, "R9");   // just above a segment centre
    step(1'b1, 12'd31,   "R9");

    // random stream with gaps and junk phases while idle
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 4) != 0, PW'($urandom), "R4");
    end

    // drain
    for (int i = 0; i < 3; i++) step(1'b0, PW'($urandom), "R6");

    check(errN > 0 && (errSum / real'(errN)) <= 0.2 && (errSum / real'(errN)) >= -0.2,
          "R3", "mean error", errSum / real'(errN > 0 ? errN : 1), 0.0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule